// File: doc/BRIEF.md
# Hierarchical Instrument Status Register Array

This block collects event pulses from an instrument into three sticky event groups: serial-link errors (8 bits), standard events (8 bits) and overloads (3 bits). Each group has its own enable mask. When a set event bit lines up with a set enable bit, the group raises a summary bit. The three summaries and a live idle level together form a status byte. That byte is masked by a service-request enable register to give one master summary line, which the host uses to decide whether the instrument needs attention.

Software reaches every register through one small port: an address, a read strobe and a write strobe. Reading an event register returns its contents and clears it in the same access. Reading the status byte or any mask has no side effect. An event that arrives during the clearing read is kept, so no pulse is lost.

Top module: `instr_status_array`

## Requirements
- R1: A 1 on any event input bit sets the matching bit of its event register at the next clock edge.
- R2: An event bit stays set until its register is read. A write to an event address (0, 2 or 4) changes nothing.
- R3: A read of an event register returns its current contents on reg_rdata in the same cycle and clears it at the next edge. An event pulse arriving in the cycle of that read leaves its bit set after the clear.
- R4: Each enable register can be written and read back at its own width. The overload enable keeps only bits 2:0, and bits 7:3 read as 0.
- R5: A group summary is 1 exactly when some bit position is 1 in both the event register and its enable register.
- R6: Serial-link error bits, from 7 down to 0: device clear, CTS halted, RTS halted, buffer overrun, hardware overrun, noise, framing, parity. Its summary drives status byte bit 7.
- R7: Standard event bits, from 7 down to 0: power on, user request, command error, execution error, device error, query error, input buffer error, operation complete. Reset leaves this register at 0x80 and all other event and enable registers at 0. Its summary drives status byte bit 5.
- R8: Overload bits: 0 input, 1 input plus offset, 2 output. Bits 7:3 of the overload event register read 0. Its summary drives status byte bit 0.
- R9: The status byte carries bit 4 equal to the live idle input, which is not latched, and bits 3:1 equal to 0.
- R10: The master summary appears on srq_o and on status byte bit 6. It is the OR over bits 7, 5:0 of (status byte AND service-request enable). Enable bit 6 has no effect.
- R11: Reading the status byte, the service-request enable or any group enable leaves all register contents unchanged.
- R12: Address map: 0 link-error events, 1 link-error enable, 2 standard events, 3 standard enable, 4 overload events, 5 overload enable, 6 status byte (read only), 7 service-request enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_evt_i | input | 8 | Serial-link error event pulses |
| std_evt_i | input | 8 | Standard event pulses |
| ovl_evt_i | input | 3 | Overload event pulses |
| idle_i | input | 1 | Live idle level |
| reg_addr | input | 3 | Register address |
| reg_rd | input | 1 | Read strobe; clears an addressed event register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| stat_byte_o | output | 8 | Live status byte |
| srq_o | output | 1 | Master summary |

## Verification
On every cycle, the assertions check four things: event capture, stickiness without a read, the clear with a colliding pulse kept, and the stability of the masks across reads. They also check that the overload readback pads with zeros. The bench's scenarios are needed for the rest: the reset value 0x80, the placement of each summary and of idle in the status byte, the fact that enable bit 6 is ignored, and the full address map. Only the bench shows that a write to an event address is dropped, and that repeated status-byte reads return the same value.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned LINK_W = 8;
  localparam int unsigned STD_W  = 8;
  localparam int unsigned OVL_W  = 3;
  localparam int unsigned AW     = 3;
  localparam int unsigned SB_LINK = 7;
  localparam int unsigned SB_MSS  = 6;
  localparam int unsigned SB_STD  = 5;
  localparam int unsigned SB_IDLE = 4;
  localparam int unsigned SB_OVL  = 0;

  typedef enum logic [AW-1:0] {
    A_LINK_EV = 3'd0,
    A_LINK_EN = 3'd1,
    A_STD_EV  = 3'd2,
    A_STD_EN  = 3'd3,
    A_OVL_EV  = 3'd4,
    A_OVL_EN  = 3'd5,
    A_SBYTE   = 3'd6,
    A_SRQ_EN  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/evt_group.sv
module evt_group #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_i,
  input  logic         rd_clr_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wd_i,
  output logic [W-1:0] ev_q_o,
  output logic [W-1:0] en_q_o,
  output logic         sum_o
);
  logic [W-1:0] ev_d, ev_q, en_d, en_q;

  always_comb begin
    ev_d = (rd_clr_i ? '0 : ev_q) | ev_i;
    en_d = en_we_i ? en_wd_i : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q <= RST_VAL;
      en_q <= '0;
    end else begin
      ev_q <= ev_d;
      en_q <= en_d;
    end
  end

  assign ev_q_o = ev_q;
  assign en_q_o = en_q;
  assign sum_o  = |(ev_q & en_q);

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((ev_q & $past(ev_i)) == $past(ev_i)));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr_i |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

  assert_clear_keeps_new_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> (ev_q == $past(ev_i)));
endmodule

// File: rtl/sb_summary.sv
module sb_summary
  import status_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_sum_i,
  input  logic          std_sum_i,
  input  logic          ovl_sum_i,
  input  logic          idle_i,
  input  logic          sre_we_i,
  input  logic [DW-1:0] sre_wd_i,
  output logic [DW-1:0] sre_q_o,
  output logic [DW-1:0] sb_o,
  output logic          mss_o
);
  logic [DW-1:0] sre_d, sre_q, base, mask;

  always_comb begin
    sre_d = sre_we_i ? sre_wd_i : sre_q;
    base  = '0;
    base[SB_LINK] = link_sum_i;
    base[SB_STD]  = std_sum_i;
    base[SB_IDLE] = idle_i;
    base[SB_OVL]  = ovl_sum_i;
    mask = sre_q;
    mask[SB_MSS] = 1'b0;
    mss_o = |(base & mask);
    sb_o = base;
    sb_o[SB_MSS] = mss_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sre_q <= '0;
    else        sre_q <= sre_d;
  end

  assign sre_q_o = sre_q;
endmodule

// File: rtl/instr_status_array.sv
module instr_status_array
  import status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINK_W-1:0] link_evt_i,
  input  logic [STD_W-1:0]  std_evt_i,
  input  logic [OVL_W-1:0]  ovl_evt_i,
  input  logic              idle_i,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [DW-1:0]     stat_byte_o,
  output logic              srq_o
);
  localparam logic [STD_W-1:0] STD_RST = STD_W'(1) << (STD_W - 1);

  logic rst_n_s;
  reg_addr_e addr;
  logic [LINK_W-1:0] link_ev, link_en;
  logic [STD_W-1:0]  std_ev, std_en;
  logic [OVL_W-1:0]  ovl_ev, ovl_en;
  logic [DW-1:0]     sre_q, sb;
  logic link_sum, std_sum, ovl_sum, mss;

  assign addr = reg_addr_e'(reg_addr);

  rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s));

  evt_group #(.W(LINK_W), .RST_VAL('0)) u_link (
    .clk(clk), .rst_n(rst_n_s), .ev_i(link_evt_i),
    .rd_clr_i(reg_rd && addr == A_LINK_EV),
    .en_we_i(reg_wr && addr == A_LINK_EN), .en_wd_i(reg_wdata[LINK_W-1:0]),
    .ev_q_o(link_ev), .en_q_o(link_en), .sum_o(link_sum));

  evt_group #(.W(STD_W), .RST_VAL(STD_RST)) u_std (
    .clk(clk), .rst_n(rst_n_s), .ev_i(std_evt_i),
    .rd_clr_i(reg_rd && addr == A_STD_EV),
    .en_we_i(reg_wr && addr == A_STD_EN), .en_wd_i(reg_wdata[STD_W-1:0]),
    .ev_q_o(std_ev), .en_q_o(std_en), .sum_o(std_sum));

  evt_group #(.W(OVL_W), .RST_VAL('0)) u_ovl (
    .clk(clk), .rst_n(rst_n_s), .ev_i(ovl_evt_i),
    .rd_clr_i(reg_rd && addr == A_OVL_EV),
    .en_we_i(reg_wr && addr == A_OVL_EN), .en_wd_i(reg_wdata[OVL_W-1:0]),
    .ev_q_o(ovl_ev), .en_q_o(ovl_en), .sum_o(ovl_sum));

  sb_summary u_sb (
    .clk(clk), .rst_n(rst_n_s),
    .link_sum_i(link_sum), .std_sum_i(std_sum), .ovl_sum_i(ovl_sum),
    .idle_i(idle_i), .sre_we_i(reg_wr && addr == A_SRQ_EN),
    .sre_wd_i(reg_wdata), .sre_q_o(sre_q), .sb_o(sb), .mss_o(mss));

  always_comb begin
    reg_rdata = '0;
    unique case (addr)
      A_LINK_EV: reg_rdata = DW'(link_ev);
      A_LINK_EN: reg_rdata = DW'(link_en);
      A_STD_EV:  reg_rdata = DW'(std_ev);
      A_STD_EN:  reg_rdata = DW'(std_en);
      A_OVL_EV:  reg_rdata = DW'(ovl_ev);
      A_OVL_EN:  reg_rdata = DW'(ovl_en);
      A_SBYTE:   reg_rdata = sb;
      A_SRQ_EN:  reg_rdata = sre_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign stat_byte_o = sb;
  assign srq_o       = mss;

  assert_ovl_pad_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (addr == A_OVL_EV || addr == A_OVL_EN) |-> (reg_rdata[DW-1:OVL_W] == '0));

  assert_read_no_side_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_rd && !reg_wr) |=> ($stable(link_en) && $stable(std_en)
                             && $stable(ovl_en) && $stable(sre_q)));
endmodule

// File: tb/tb_instr_status_array.sv
module tb_instr_status_array;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] link_evt_i = '0, std_evt_i = '0;
  logic [2:0] ovl_evt_i = '0;
  logic       idle_i = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, stat_byte_o;
  logic       srq_o;

  instr_status_array dut (.*);

  always #5 clk = ~clk;

  typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
  item_t scb[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (scb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = scb.pop_front();
      act = (it.kind == 0) ? reg_rdata : (it.kind == 1) ? stat_byte_o : {7'd0, srq_o};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    reg_addr = a; reg_rd = 1'b1;
    scb.push_back('{0, e, tag});
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic peek(input int kind, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    scb.push_back('{kind, e, tag});
    @(posedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] l, input logic [7:0] s, input logic [2:0] o);
    @(posedge clk); #1;
    link_evt_i = l; std_evt_i = s; ovl_evt_i = o;
    @(posedge clk); #1;
    link_evt_i = '0; std_evt_i = '0; ovl_evt_i = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    peek(1, 8'h00, "R9 reset status byte");
    peek(2, 8'h00, "R10 reset srq");
    rd(3'd2, 8'h80, "R7 power-on bit after reset");
    rd(3'd2, 8'h00, "R3 std cleared by read");
    rd(3'd1, 8'h00, "R7 link enable reset");
    pulse(8'h01, 8'h00, 3'b000);
    pulse(8'h04, 8'h00, 3'b000);
    repeat (3) @(posedge clk);
    wr(3'd0, 8'h00);
    rd(3'd0, 8'h05, "R2 sticky, write ignored");
    rd(3'd0, 8'h00, "R3 link cleared");
    pulse(8'h00, 8'h00, 3'b101);
    rd(3'd4, 8'h05, "R8 overload bits");
    wr(3'd5, 8'hFF);
    rd(3'd5, 8'h07, "R4 overload enable width");
    pulse(8'h00, 8'h00, 3'b010);
    peek(1, 8'h01, "R5 overload summary set");
    wr(3'd5, 8'h05);
    peek(1, 8'h00, "R5 no overlap no summary");
    idle_i = 1'b1;
    peek(1, 8'h10, "R9 idle live high");
    idle_i = 1'b0;
    peek(1, 8'h00, "R9 idle live low");
    wr(3'd5, 8'h07);
    wr(3'd7, 8'h01);
    peek(2, 8'h01, "R10 srq from overload");
    peek(1, 8'h41, "R10 status byte bit6");
    wr(3'd7, 8'h40);
    peek(2, 8'h00, "R10 enable bit6 ignored");
    rd(3'd7, 8'h40, "R12 srq enable readback");
    rd(3'd6, 8'h01, "R11 status byte read");
    rd(3'd6, 8'h01, "R11 status byte reread");
    rd(3'd5, 8'h07, "R11 enable unchanged");
    rd(3'd4, 8'h02, "R11 overload event kept");
    pulse(8'h02, 8'h00, 3'b010);
    wr(3'd1, 8'h80);
    pulse(8'h80, 8'h00, 3'b000);
    peek(1, 8'h81, "R6 link summary at bit7");
    wr(3'd3, 8'h01);
    pulse(8'h00, 8'h01, 3'b000);
    peek(1, 8'hA1, "R7 std summary at bit5");
    wr(3'd7, 8'hFF);
    peek(1, 8'hE1, "R10 full enable");
    // R3 collision: pulse during clearing read
    @(posedge clk); #1;
    reg_addr = 3'd2; reg_rd = 1'b1; std_evt_i = 8'h01;
    scb.push_back('{0, 8'h01, "R3 read before collision"});
    @(posedge clk); #1;
    reg_rd = 1'b0; std_evt_i = '0;
    rd(3'd2, 8'h01, "R3 colliding event kept");
    rd(3'd2, 8'h00, "R3 cleared afterwards");
    rd(3'd0, 8'h82, "R1 link capture");
    rd(3'd1, 8'h80, "R12 link enable address");
    rd(3'd3, 8'h01, "R12 std enable address");
    peek(1, 8'h41, "R5 summaries follow clears");
    repeat (2) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule